// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is the clocked shift mode of a small controller's serial port. It moves one byte per frame over a single data line that can be driven or read, and it drives a separate shift clock for the device on the other end. The block runs from the oscillator clock. One bit takes one machine cycle of twelve oscillator clocks, so the shift clock runs at one twelfth of the oscillator rate.

Software starts a transmit by writing a byte through the load strobe. A receive starts by itself while the receive enable is high, the receive-done flag is clear and no frame is running. Bits travel least significant first. Transmit data changes well before each rising shift-clock edge and is held briefly after it. Receive data is sampled on the rising edge. When a frame ends, a transmit-done or receive-done flag is set and stays set until software clears it.

The bidirectional data line is split into an output value, an output enable and an input value. Pad logic outside the block joins them.

Top module: `ssp_sync_shift`

## Requirements
- R1: During and after reset, `sclk` is 1, `sd_oe` is 0, `sd_out` is 1, and both `tx_done` and `rx_done` are 0.
- R2: A `tx_load` pulse while idle starts a frame on that clock edge. `sd_oe` is 1 for the 96 clocks of the frame. Bit b of `tx_byte` (b = 0 first, least significant bit first) sits on `sd_out` for clocks 12b to 12b+11 after the start edge.
- R3: `sclk` is 1 whenever no frame runs. Within each 12-clock bit slot, at slot phase p (0 to 11, counted from the start edge), `sclk` is 0 for p = 4 to 9 and 1 otherwise. A frame therefore has exactly 8 low pulses.
- R4: Each transmit bit is on `sd_out` 10 clocks before the rising `sclk` edge of its slot (phase 10). It is held for 2 clocks after that edge.
- R5: In a receive frame, `sd_in` is captured on the clock edge where `sclk` rises (into phase 10), least significant bit first. `sd_oe` stays 0, and `rx_byte` holds the assembled byte when `rx_done` sets.
- R6: `tx_done` (after a transmit) or `rx_done` (after a receive) becomes 1 on the 96th clock edge after the start edge. At that same edge `sd_oe` returns to 0 and `sclk` stays high.
- R7: A set flag stays 1 until its clear input (`clr_tx_done` or `clr_rx_done`) is high at a clock edge. The flag then reads 0 after that edge.
- R8: A `tx_load` during a running frame is ignored. The frame keeps its original bits, and no second frame follows.
- R9: A receive frame starts only on an edge where `rx_enable` is 1, `rx_done` is 0 and no frame runs. With `rx_done` set, `sclk` stays high no matter what `rx_enable` does.
- R10: When `tx_load` and a receive start fall on the same idle edge, the transmit frame is the one that runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_load | input | 1 | Write strobe that starts a transmit frame |
| tx_byte | input | 8 | Byte to transmit, sampled with `tx_load` |
| rx_enable | input | 1 | Allows a receive frame to start |
| clr_tx_done | input | 1 | Clears the transmit-done flag |
| clr_rx_done | input | 1 | Clears the receive-done flag |
| sd_in | input | 1 | Data line value read from the pad |
| sd_out | output | 1 | Data line value to drive |
| sd_oe | output | 1 | Data line output enable (1 during transmit) |
| sclk | output | 1 | Shift clock, idles high |
| rx_byte | output | 8 | Received byte |
| tx_done | output | 1 | Transmit-done flag |
| rx_done | output | 1 | Receive-done flag |

## Verification
The start edge is the edge that accepts `tx_load` or a receive start. From there, results fall on fixed clock counts. Transmit bit b appears on `sd_out` right after edge 12b. `sclk` goes low after edge 12b+4 and high after edge 12b+10. The flags and the drop of `sd_oe` show after edge 96. A clear shows one edge after it is applied. The bench drives inputs on falling edges and samples outputs on falling edges. It tracks the edge count from the start edge and tests each output only at its due edge and at the edge just before it. The receive stimulus changes `sd_in` to the wrong value right after each sampling edge, so a sample taken late is caught.

// File: rtl/ssp_pkg.sv
// Package: shared types for the synchronous shift serial port.
// Assumes: one frame kind is active at a time.
package ssp_pkg;
    typedef enum logic [1:0] {
        XFER_IDLE = 2'd0,
        XFER_TX   = 2'd1,
        XFER_RX   = 2'd2
    } xfer_mode_e;
endpackage

// File: rtl/ssp_phase_gen.sv
// Bit-slot timer: counts oscillator clocks inside each machine-cycle bit
// slot and counts bits inside a frame. It derives the shift clock, the
// sample strobe and the frame end. Assumes start is only raised while idle.
module ssp_phase_gen #(
    parameter int OSC_PER_BIT = 12,
    parameter int FRAME_BITS  = 8,
    parameter int SETUP_CLKS  = 10,
    parameter int LOW_CLKS    = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active,
    output logic slot_end,
    output logic frame_end,
    output logic sample_now,
    output logic sclk
);
    localparam int PH_W  = $clog2(OSC_PER_BIT);
    localparam int BIT_W = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(OSC_PER_BIT - 1);
    localparam logic [PH_W-1:0]  PH_RISE  = PH_W'(SETUP_CLKS);
    localparam logic [PH_W-1:0]  PH_LOW   = PH_W'(SETUP_CLKS - LOW_CLKS);
    localparam logic [PH_W-1:0]  PH_SAMP  = PH_W'(SETUP_CLKS - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_BITS - 1);

    logic [PH_W-1:0]  phase_q;
    logic [BIT_W-1:0] bit_q;

    // Decode slot and frame boundaries from the counters.
    always_comb begin
        slot_end   = active && (phase_q == PH_LAST);
        frame_end  = slot_end && (bit_q == BIT_LAST);
        sample_now = active && (phase_q == PH_SAMP);
        sclk       = !(active && (phase_q >= PH_LOW) && (phase_q < PH_RISE));
    end

    // Advance the phase and bit counters and track frame activity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            phase_q <= '0;
            bit_q   <= '0;
        end else if (start) begin
            active  <= 1'b1;
            phase_q <= '0;
            bit_q   <= '0;
        end else if (active) begin
            if (slot_end) begin
                phase_q <= '0;
                bit_q   <= bit_q + 1'b1;
                if (frame_end) active <= 1'b0;
            end else begin
                phase_q <= phase_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ssp_shifter.sv
// Data path: holds the frame kind and the transmit and receive shift
// registers. It presents transmit bits least significant first and
// captures receive bits at the sample strobe. Assumes the start strobes
// are mutually exclusive and only raised while idle.
module ssp_shifter
    import ssp_pkg::*;
#(
    parameter int FRAME_BITS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_tx,
    input  logic                  start_rx,
    input  logic [FRAME_BITS-1:0] tx_byte,
    input  logic                  slot_end,
    input  logic                  frame_end,
    input  logic                  sample_now,
    input  logic                  sd_in,
    output xfer_mode_e            mode,
    output logic                  sd_out,
    output logic                  sd_oe,
    output logic [FRAME_BITS-1:0] rx_byte
);
    logic [FRAME_BITS-1:0] tx_sr;

    // The line is driven only while a transmit frame runs.
    always_comb sd_oe = (mode == XFER_TX);

    // Frame kind plus transmit shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode   <= XFER_IDLE;
            sd_out <= 1'b1;
            tx_sr  <= '0;
        end else if (start_tx) begin
            mode   <= XFER_TX;
            sd_out <= tx_byte[0];
            tx_sr  <= tx_byte >> 1;
        end else if (start_rx) begin
            mode   <= XFER_RX;
        end else if (frame_end) begin
            mode   <= XFER_IDLE;
            sd_out <= 1'b1;
        end else if (slot_end && mode == XFER_TX) begin
            sd_out <= tx_sr[0];
            tx_sr  <= tx_sr >> 1;
        end
    end

    // Receive capture, least significant bit first, at the rising shift clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_byte <= '0;
        end else if (sample_now && mode == XFER_RX) begin
            rx_byte <= {sd_in, rx_byte[FRAME_BITS-1:1]};
        end
    end
endmodule

// File: rtl/ssp_flags.sv
// Completion flags: each flag sets on its event and stays set until its
// clear input is seen. A set wins over a clear in the same cycle.
module ssp_flags #(
    parameter int NUM_FLAGS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] set_i,
    input  logic [NUM_FLAGS-1:0] clr_i,
    output logic [NUM_FLAGS-1:0] flag_o
);
    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        // Sticky flag register for one event.
        always_ff @(posedge clk) begin
            if (!rst_n)        flag_o[i] <= 1'b0;
            else if (set_i[i]) flag_o[i] <= 1'b1;
            else if (clr_i[i]) flag_o[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/ssp_sync_shift.sv
// Top: synchronous shift serial port. It decides when a frame starts
// (transmit wins over receive) and wires the timer, data path and flags.
// Assumes a bidirectional pad outside joins sd_out, sd_oe and sd_in.
module ssp_sync_shift
    import ssp_pkg::*;
#(
    parameter int OSC_PER_BIT = 12,
    parameter int FRAME_BITS  = 8,
    parameter int SETUP_CLKS  = 10,
    parameter int LOW_CLKS    = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tx_load,
    input  logic [FRAME_BITS-1:0] tx_byte,
    input  logic                  rx_enable,
    input  logic                  clr_tx_done,
    input  logic                  clr_rx_done,
    input  logic                  sd_in,
    output logic                  sd_out,
    output logic                  sd_oe,
    output logic                  sclk,
    output logic [FRAME_BITS-1:0] rx_byte,
    output logic                  tx_done,
    output logic                  rx_done
);
    localparam int FLAG_TX = 0;
    localparam int FLAG_RX = 1;

    logic       frame_active;
    logic       slot_end, frame_end, sample_now;
    logic       start_tx, start_rx;
    xfer_mode_e mode;
    logic [1:0] flag_set, flag_clr, flags;

    // Start arbitration: a load wins over a pending receive.
    always_comb begin
        start_tx = tx_load && !frame_active;
        start_rx = rx_enable && !rx_done && !frame_active && !tx_load;
        flag_set[FLAG_TX] = frame_end && (mode == XFER_TX);
        flag_set[FLAG_RX] = frame_end && (mode == XFER_RX);
        flag_clr[FLAG_TX] = clr_tx_done;
        flag_clr[FLAG_RX] = clr_rx_done;
        tx_done = flags[FLAG_TX];
        rx_done = flags[FLAG_RX];
    end

    ssp_phase_gen #(
        .OSC_PER_BIT(OSC_PER_BIT),
        .FRAME_BITS (FRAME_BITS),
        .SETUP_CLKS (SETUP_CLKS),
        .LOW_CLKS   (LOW_CLKS)
    ) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_tx || start_rx),
        .active    (frame_active),
        .slot_end  (slot_end),
        .frame_end (frame_end),
        .sample_now(sample_now),
        .sclk      (sclk)
    );

    ssp_shifter #(
        .FRAME_BITS(FRAME_BITS)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_tx  (start_tx),
        .start_rx  (start_rx),
        .tx_byte   (tx_byte),
        .slot_end  (slot_end),
        .frame_end (frame_end),
        .sample_now(sample_now),
        .sd_in     (sd_in),
        .mode      (mode),
        .sd_out    (sd_out),
        .sd_oe     (sd_oe),
        .rx_byte   (rx_byte)
    );

    ssp_flags #(
        .NUM_FLAGS(2)
    ) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (flag_set),
        .clr_i (flag_clr),
        .flag_o(flags)
    );
endmodule

// File: rtl/ssp_sync_shift_checker.sv
// Checker: temporal properties of the serial port, bound to the top.
module ssp_sync_shift_checker (
    input logic clk,
    input logic rst_n,
    input logic tx_load,
    input logic clr_tx_done,
    input logic clr_rx_done,
    input logic sclk,
    input logic sd_out,
    input logic sd_oe,
    input logic tx_done,
    input logic rx_done,
    input logic frame_active
);
    AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_active |-> sclk); // R3
    AST_OE_ONLY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        sd_oe |-> frame_active); // R2
    AST_DATA_STEADY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_oe && !sclk && !$past(sclk)) |-> $stable(sd_out)); // R4
    AST_TX_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && !clr_tx_done) |=> tx_done); // R7
    AST_RX_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !clr_rx_done) |=> rx_done); // R7
    AST_TX_FLAG_AFTER_TX: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> $past(sd_oe)); // R6
    AST_RX_FLAG_AFTER_RX: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_done) |-> $past(frame_active && !sd_oe)); // R5
    AST_RX_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_active && rx_done && !tx_load) |=> !frame_active); // R9
    AST_TX_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_active && tx_load) |=> sd_oe); // R10
endmodule

bind ssp_sync_shift ssp_sync_shift_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_load     (tx_load),
    .clr_tx_done (clr_tx_done),
    .clr_rx_done (clr_rx_done),
    .sclk        (sclk),
    .sd_out      (sd_out),
    .sd_oe       (sd_oe),
    .tx_done     (tx_done),
    .rx_done     (rx_done),
    .frame_active(frame_active)
);

// File: tb/ssp_sync_shift_bench.sv
module ssp_sync_shift_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_load = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       rx_enable = 1'b0;
    logic       clr_tx_done = 1'b0;
    logic       clr_rx_done = 1'b0;
    logic       sd_in = 1'b0;
    logic       sd_out, sd_oe, sclk, tx_done, rx_done;
    logic [7:0] rx_byte;
    int         checks = 0;
    int         errors = 0;
    bit         finished = 1'b0;

    always #10 clk = ~clk;

    ssp_sync_shift u_ssp_sync_shift (
        .clk(clk), .rst_n(rst_n), .tx_load(tx_load), .tx_byte(tx_byte),
        .rx_enable(rx_enable), .clr_tx_done(clr_tx_done), .clr_rx_done(clr_rx_done),
        .sd_in(sd_in), .sd_out(sd_out), .sd_oe(sd_oe), .sclk(sclk),
        .rx_byte(rx_byte), .tx_done(tx_done), .rx_done(rx_done)
    );

    // Vector table: {is_transmit, byte}; the expected line bits / rx_byte is the byte.
    localparam logic [8:0] VECS [8] = '{
        {1'b1, 8'hA5}, {1'b1, 8'h01}, {1'b1, 8'h80}, {1'b0, 8'h3C},
        {1'b0, 8'hFF}, {1'b0, 8'h00}, {1'b1, 8'h5A}, {1'b0, 8'hC1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Run one frame, checking every output at its due edge k after the start edge.
    task automatic run_frame(input logic is_tx, input logic [7:0] d, input int inject_at);
        @(negedge clk);
        if (is_tx) begin tx_load = 1'b1; tx_byte = d; end
        else rx_enable = 1'b1;
        tick();
        tx_load = 1'b0;
        rx_enable = 1'b0;
        for (int k = 0; k <= 96; k++) begin
            if (k > 0) tick();
            tx_load = 1'b0;
            if (k == inject_at) begin tx_load = 1'b1; tx_byte = ~d; end
            if (k < 96) begin
                if (is_tx) begin
                    if (k % 12 == 0) check("R2 bit on line at slot start", sd_out, d[k/12]);
                    if (k % 12 == 5) check("R2 output enable in frame", sd_oe, 1);
                    if (k % 12 == 11) check("R4 bit held after rise", sd_out, d[k/12]);
                    if (k % 12 == 10) check("R4 bit stable at rise", sd_out, d[k/12]);
                end else begin
                    if (k % 12 == 1) sd_in = d[k/12];
                    if (k % 12 == 10) sd_in = ~d[k/12];
                    if (k % 12 == 5) check("R5 line not driven in receive", sd_oe, 0);
                end
                if (k % 12 == 5) check("R3 sclk low mid slot", sclk, 0);
                if (k % 12 == 10) check("R3 sclk high after rise", sclk, 1);
                if (k == 95) check("R6 flag not early", is_tx ? tx_done : rx_done, 0);
            end else begin
                check("R6 flag set at edge 96", is_tx ? tx_done : rx_done, 1);
                check("R6 line released at end", sd_oe, 0);
                check("R6 sclk high at end", sclk, 1);
                if (!is_tx) check("R5 received byte", rx_byte, d);
            end
        end
        tx_load = 1'b0;
        sd_in = 1'b0;
    endtask

    task automatic clear_flags();
        clr_tx_done = 1'b1;
        clr_rx_done = 1'b1;
        tick();
        clr_tx_done = 1'b0;
        clr_rx_done = 1'b0;
        check("R7 tx flag cleared", tx_done, 0);
        check("R7 rx flag cleared", rx_done, 0);
    endtask

    initial begin
        int lows;
        // R1: reset state
        repeat (3) tick();
        check("R1 sclk idle high", sclk, 1);
        check("R1 oe low", sd_oe, 0);
        check("R1 sd_out high", sd_out, 1);
        check("R1 flags clear", {tx_done, rx_done}, 0);
        rst_n = 1'b1;
        repeat (5) tick();
        check("R9 no frame without enable", sclk, 1);

        // Table-driven frames
        for (int i = 0; i < 8; i++) begin
            run_frame(VECS[i][8], VECS[i][7:0], -1);
            clear_flags();
        end

        // R7: flag sticks without a clear
        run_frame(1'b1, 8'h96, -1);
        repeat (30) tick();
        check("R7 tx flag still set", tx_done, 1);
        clear_flags();

        // R8: write mid-frame is ignored
        run_frame(1'b1, 8'hC3, 30);
        repeat (12) tick();
        check("R8 no second frame", sd_oe, 0);
        check("R8 sclk idle", sclk, 1);
        clear_flags();

        // R9: receive held off while rx_done set
        run_frame(1'b0, 8'h69, -1);
        rx_enable = 1'b1;
        lows = 0;
        for (int k = 0; k < 30; k++) begin
            tick();
            if (!sclk) lows++;
        end
        check("R9 no receive while done set", lows, 0);
        clr_rx_done = 1'b1;
        tick();
        clr_rx_done = 1'b0;
        repeat (5) tick();
        check("R9 receive starts after clear", sclk, 0);
        rx_enable = 1'b0;
        repeat (100) tick();
        clear_flags();

        // R10: load and receive start on the same edge
        tx_load = 1'b1;
        tx_byte = 8'h0F;
        rx_enable = 1'b1;
        tick();
        tx_load = 1'b0;
        rx_enable = 1'b0;
        repeat (5) tick();
        check("R10 transmit wins", sd_oe, 1);
        repeat (91) tick();
        check("R10 tx flag set", tx_done, 1);
        check("R10 rx flag clear", rx_done, 0);
        clear_flags();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        finished = 1'b1;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule